// File: doc/BRIEF.md
# Multi-Pattern Serial Test Sequence Generator

This block emits one serial test bit per enabled clock cycle for line-level self-test and maintenance. A configuration input picks the pattern: a 15-stage or a 20-stage maximal-length pseudorandom sequence, an alternating zero/one stream, or a constant stream of ones. A bit-enable strobe sets the line rate, so one fast system clock can serve slower lines.

In unframed operation every enabled bit carries the pattern. In framed operation an external framer raises a payload-enable input on payload bit times. On overhead bit times the generator drives zero and freezes its sequence state, so the framer can overlay its overhead. A rising edge on the error request input flips exactly one later transmitted bit. This makes it possible to test error counting at the far-end monitor.

Top module: `seq_test_gen`

## Requirements
- R1: After reset data_o is 0, both pseudorandom registers hold the all-ones seed, and the alternating toggle is 0.
- R2: With pat_sel_i = 0 the output is a pseudorandom sequence with polynomial x^15 + x^14 + 1. Each transmitted bit is stage 15 of a left-shifting register, and the new stage 1 is stage 15 XOR stage 14. The register is seeded with all ones.
- R3: With pat_sel_i = 1 the output follows the same scheme with polynomial x^20 + x^17 + 1. The new stage 1 is stage 20 XOR stage 17, and the register is seeded with all ones.
- R4: With pat_sel_i = 2 the output alternates 0,1,0,1 on transmitted bits, starting with 0 after a select change.
- R5: With pat_sel_i = 3 every transmitted bit is 1.
- R6: On a cycle with bit_en_i low, data_o and all pattern state hold.
- R7: With framed_i low, every cycle with bit_en_i high transmits the next pattern bit.
- R8: With framed_i high, a cycle with bit_en_i high and pay_en_i low drives data_o to 0 and leaves the pattern state unchanged. The pattern continues on the next payload bit.
- R9: A rising edge on err_req_i inverts exactly one transmitted bit. If a bit is transmitted in the same cycle as the edge, that bit is inverted. Otherwise the next transmitted bit is inverted.
- R10: Further rising edges while an error is pending merge with it and still invert only one bit.
- R11: A transmitted bit whose pat_sel_i differs from the select of the previous transmitted bit restarts the pattern from its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-time strobe; one bit slot per high cycle |
| framed_i | input | 1 | 1 = framed payload mode, 0 = unframed |
| pay_en_i | input | 1 | Payload bit marker from the framer (framed mode) |
| pat_sel_i | input | 2 | 0 PRBS15, 1 PRBS20, 2 alternating, 3 all ones |
| err_req_i | input | 1 | Single-bit error request, rising-edge active |
| data_o | output | 1 | Registered serial test bit |

## Verification
The bench builds the block with its default parameters: a 15-stage and a 20-stage register, both with taps at the polynomial exponents and both seeded with all ones. These defaults make the bench's own shift-register model line up bit for bit over several hundred transmitted bits of each sequence. They also make seed reload on select change visible within the first 20 bits. The vector table covers the deterministic patterns through idle, overhead and error slots. Directed runs cover pseudorandom pausing in framed mode and the merging of error requests.

// File: rtl/seq_test_gen_pkg.sv
package seq_test_gen_pkg;
  typedef enum logic [1:0] {
    PAT_PN15 = 2'd0,
    PAT_PN20 = 2'd1,
    PAT_ALT  = 2'd2,
    PAT_ONES = 2'd3
  } pat_e;

  localparam int unsigned NUM_PN = 2;
endpackage

// File: rtl/stg_lfsr.sv
module stg_lfsr #(
  parameter int unsigned WIDTH = 15,
  parameter int unsigned TAP_HI = 15,
  parameter int unsigned TAP_LO = 14,
  parameter logic [WIDTH-1:0] SEED = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic load_i,
  output logic bit_o
);
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] cur;
  logic             fb;

  // a load presents the seed to the current bit
  assign cur   = load_i ? SEED : state_q;
  assign bit_o = cur[WIDTH-1];
  assign fb    = cur[TAP_HI-1] ^ cur[TAP_LO-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= SEED;
    else if (step_i)  state_q <= {cur[WIDTH-2:0], fb};
  end
endmodule

// File: rtl/stg_alt.sv
module stg_alt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic load_i,
  output logic bit_o
);
  logic tog_q;
  logic cur;

  assign cur   = load_i ? 1'b0 : tog_q;
  assign bit_o = cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tog_q <= 1'b0;
    else if (step_i) tog_q <= ~cur;
  end
endmodule

// File: rtl/stg_err.sv
module stg_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic tx_i,
  output logic flip_o,
  output logic pend_o
);
  logic req_q;
  logic pend_q;
  logic rise;

  assign rise   = req_i & ~req_q;
  assign flip_o = pend_q | rise;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q  <= req_i;
      pend_q <= tx_i ? 1'b0 : flip_o;
    end
  end
endmodule

// File: rtl/seq_test_gen.sv
module seq_test_gen
  import seq_test_gen_pkg::*;
#(
  parameter int unsigned PN15_W = 15,
  parameter int unsigned PN15_T = 14,
  parameter int unsigned PN20_W = 20,
  parameter int unsigned PN20_T = 17
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       framed_i,
  input  logic       pay_en_i,
  input  logic [1:0] pat_sel_i,
  input  logic       err_req_i,
  output logic       data_o
);
  localparam int unsigned PN_W [NUM_PN] = '{PN15_W, PN20_W};
  localparam int unsigned PN_T [NUM_PN] = '{PN15_T, PN20_T};

  logic              tx;
  logic              sel_chg;
  pat_e              sel;
  pat_e              sel_q;
  logic [NUM_PN-1:0] pn_bit;
  logic              alt_bit;
  logic              pat_bit;
  logic              flip;
  logic              err_pend;

  assign sel     = pat_e'(pat_sel_i);
  assign tx      = bit_en_i & (~framed_i | pay_en_i);
  assign sel_chg = (sel != sel_q);

  for (genvar g = 0; g < NUM_PN; g++) begin : g_pn
    stg_lfsr #(
      .WIDTH (PN_W[g]),
      .TAP_HI(PN_W[g]),
      .TAP_LO(PN_T[g]),
      .SEED  ({PN_W[g]{1'b1}})
    ) u_lfsr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .step_i(tx && (sel == pat_e'(g))),
      .load_i(sel_chg),
      .bit_o (pn_bit[g])
    );
  end

  stg_alt u_alt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(tx && (sel == PAT_ALT)),
    .load_i(sel_chg),
    .bit_o (alt_bit)
  );

  stg_err u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (err_req_i),
    .tx_i  (tx),
    .flip_o(flip),
    .pend_o(err_pend)
  );

  always_comb begin
    unique case (sel)
      PAT_PN15: pat_bit = pn_bit[0];
      PAT_PN20: pat_bit = pn_bit[1];
      PAT_ALT:  pat_bit = alt_bit;
      default:  pat_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= 1'b0;
      sel_q  <= PAT_PN15;
    end else if (bit_en_i) begin
      // overhead slots are left at zero for the framer
      data_o <= tx ? (pat_bit ^ flip) : 1'b0;
      if (tx) sel_q <= sel;
    end
  end
endmodule

// File: rtl/seq_test_gen_chk.sv
module seq_test_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_en_i,
  input logic       framed_i,
  input logic       pay_en_i,
  input logic [1:0] pat_sel_i,
  input logic       err_req_i,
  input logic       data_o,
  input logic       err_pend
);
  logic tx;
  logic req_q;
  assign tx = bit_en_i & (~framed_i | pay_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= err_req_i;
  end

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(data_o));

  assert_overhead_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && framed_i && !pay_en_i) |=> !data_o);

  assert_ones_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx && pat_sel_i == 2'd3 && !err_pend && !(err_req_i && !req_q)) |=> data_o);

  assert_err_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx |=> !err_pend);

  assert_err_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx && (err_pend || (err_req_i && !req_q))) |=> err_pend);
endmodule

bind seq_test_gen seq_test_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bit_en_i (bit_en_i),
  .framed_i (framed_i),
  .pay_en_i (pay_en_i),
  .pat_sel_i(pat_sel_i),
  .err_req_i(err_req_i),
  .data_o   (data_o),
  .err_pend (err_pend)
);

// File: tb/seq_test_gen_test.sv
module seq_test_gen_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en_i = 1'b0;
  logic       framed_i = 1'b0;
  logic       pay_en_i = 1'b0;
  logic [1:0] pat_sel_i = 2'd2;
  logic       err_req_i = 1'b0;
  logic       data_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [14:0] m15;
  logic [19:0] m20;

  seq_test_gen uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .framed_i (framed_i),
    .pay_en_i (pay_en_i),
    .pat_sel_i(pat_sel_i),
    .err_req_i(err_req_i),
    .data_o   (data_o)
  );

  always #4 clk_i = ~clk_i;

  // {bit_en, framed, pay_en, sel[1:0], err_req, expected}
  localparam int NV = 18;
  localparam logic [6:0] VEC [NV] = '{
    7'b1_0_0_10_0_0, // R4 first alt bit after select change
    7'b1_0_0_10_0_1, // R4
    7'b1_0_0_10_0_0, // R4
    7'b0_0_0_10_0_0, // R6 idle holds
    7'b1_0_0_10_0_1, // R7
    7'b1_1_0_10_0_0, // R8 overhead zero
    7'b1_1_1_10_0_0, // R8 resumes where paused
    7'b1_1_1_10_0_1, // R8
    7'b1_0_0_10_1_1, // R9 same-cycle edge flips
    7'b1_0_0_10_1_1, // R9 level alone does nothing
    7'b1_0_0_11_0_1, // R5
    7'b1_0_0_11_0_1, // R5
    7'b0_0_0_11_1_1, // R6/R9 edge while idle
    7'b1_1_0_11_0_0, // R8/R9 overhead keeps pending
    7'b1_1_1_11_0_0, // R9 flipped on next payload bit
    7'b1_1_1_11_0_1, // R9 only once
    7'b1_0_0_10_0_0, // R11 alt restarts at 0
    7'b1_0_0_10_0_1  // R11
  };

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: data_o=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic m15_out();
    return m15[14];
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    bit_en_i = 1'b0; framed_i = 1'b0; pay_en_i = 1'b0; err_req_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset", data_o, 1'b0);

    for (int i = 0; i < NV; i++) begin
      {bit_en_i, framed_i, pay_en_i, pat_sel_i, err_req_i} = VEC[i][6:1];
      cyc();
      chk($sformatf("R4-R11 vector %0d", i), data_o, VEC[i][0]);
    end

    // R2 PRBS15 from seed, with framed pauses (R8) in between
    do_reset();
    pat_sel_i = 2'd0; m15 = '1;
    for (int i = 0; i < 300; i++) begin
      logic pause;
      pause = (i % 7 == 3);
      bit_en_i = 1'b1; framed_i = 1'b1; pay_en_i = ~pause;
      cyc();
      if (pause) chk("R8 PRBS15 overhead", data_o, 1'b0);
      else begin
        chk("R2 PRBS15", data_o, m15_out());
        m15 = {m15[13:0], m15[14] ^ m15[13]};
      end
    end

    // R3 PRBS20, R11 reload on switch
    pat_sel_i = 2'd1; framed_i = 1'b0; m20 = '1;
    for (int i = 0; i < 300; i++) begin
      bit_en_i = (i % 5 != 2);
      cyc();
      if (bit_en_i) begin
        chk("R3 PRBS20", data_o, m20[19]);
        m20 = {m20[18:0], m20[19] ^ m20[16]};
      end
    end

    // R11 back to PRBS15 restarts from seed, R1 seed value
    pat_sel_i = 2'd0; m15 = '1; bit_en_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      cyc();
      chk("R11 PRBS15 reload", data_o, m15_out());
      m15 = {m15[13:0], m15[14] ^ m15[13]};
    end

    // R10 merged requests flip one bit only
    pat_sel_i = 2'd3; bit_en_i = 1'b1;
    cyc();
    bit_en_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      err_req_i = 1'b1; cyc();
      err_req_i = 1'b0; cyc();
    end
    bit_en_i = 1'b1;
    cyc();
    chk("R10 merged flip", data_o, 1'b0);
    cyc();
    chk("R10 single flip only", data_o, 1'b1);
    cyc();
    chk("R10 no second flip", data_o, 1'b1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule